// File: doc/BRIEF.md
# Variable-Latency Multiplier with Aging-Adaptive Hold Control

This block multiplies two unsigned m-bit operands and gives a 2m-bit product, taking either one or two clock cycles per operation. The multiplier itself is modelled behaviourally. The point of the block is the controller around it. Before each operation it counts the zero bits of the operand that drives the bypass lines of the array. For column bypass this is the multiplicand. For row bypass, selected by a parameter, it is the multiplicator. Enough zeros means the long carry paths are bypassed, so the product is captured at the edge that accepts the operation. Otherwise one more cycle is granted.

The capture stage reports a timing-error flag at the edge where it captures a product. A flagged capture gives no result. The operation is then re-executed with a safe two-cycle path. Each flagged capture adds one to an aging tally. A window of completed operations clears the tally from time to time, so only errors that arrive close together count. When the tally reaches its limit, the controller switches for good to a stricter judging threshold that needs one more zero before it allows single-cycle issue. Only a reset undoes this.

A user drives `start` with the operands while `busy` is low. The user then waits for the one-cycle `resultValid` pulse, and the product stays on `product` until the next good result.

Top module: `ahl_mult`

## Requirements
- R1: On every `resultValid` pulse, `product` equals the unsigned product mdIn*mrIn of the accepted operation, 2*OP_W bits wide. `product` changes only together with a `resultValid` pulse.
- R2: In normal mode (`agedMode` low), an accepted operation whose multiplicand has at least NORM_ZEROS zero bits (4 for OP_W=8) is captured at the accepting edge, and `resultValid` is high in the following cycle. With fewer zeros, the capture is one edge later and `resultValid` is high two cycles after acceptance.
- R3: In aged mode (`agedMode` high), single-cycle issue needs at least AGED_ZEROS zero bits (5 for OP_W=8). A multiplicand with exactly 4 zeros takes two cycles.
- R4: `timingErr` is sampled at the capture edge. If it is high there, no `resultValid` follows. The operation is re-executed and its correct result is flagged valid after the second edge following the flagged capture. This gives 3 cycles in total for a single-cycle operation and 4 for a two-cycle one.
- R5: `timingErr` has no effect at any edge that is not a capture edge: not during re-execution, not while idle, and not at the accepting edge of a two-cycle operation.
- R6: Each flagged capture adds one to the aging tally. When the tally reaches AGE_LIMIT (4), `agedMode` goes high and stays high until reset.
- R7: After every WINDOW_OPS (256) completed operations, counted from reset, the aging tally is cleared. Fewer than AGE_LIMIT errors before the clear plus fewer than AGE_LIMIT after it leave `agedMode` low.
- R8: `busy` is high in every cycle in which an accepted operation has not yet been captured successfully. A `start` seen while `busy` is high is ignored.
- R9: After reset, `busy`, `resultValid` and `agedMode` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue request, accepted when `busy` is low |
| mdIn | input | OP_W | Multiplicand |
| mrIn | input | OP_W | Multiplicator |
| timingErr | input | 1 | Error flag from the capture stage, sampled at capture edges |
| busy | output | 1 | Operation still in flight |
| resultValid | output | 1 | One-cycle pulse marking a correct product |
| product | output | 2*OP_W | Last correct product |
| agedMode | output | 1 | Stricter judging threshold in use |

## Verification
The latency of each result follows from its acceptance edge. A result with no error is due one or two cycles after acceptance, depending on the zero count and the current mode. A result whose capture was flagged is due three or four cycles after acceptance. After each operation is issued, the bench samples on every falling edge. It records the first cycle in which `resultValid` is high and compares that cycle number, and the product seen in it, with values it computes itself. The same falling-edge samples check `busy`, cycle by cycle, against the cycle in which the result is due. The bench sweeps all 256 multiplicands in both modes. It applies `timingErr` outside capture edges and an extra `start` during busy cycles, and it places the errors so that the clearing window decides whether aged mode is entered.

// File: rtl/ahl_pkg.sv
package ahl_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOps;   // latch operands at acceptance
    logic useHeld;   // multiply held operands instead of live inputs
    logic capture;   // load product register
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LONG  = 2'd1,
    ST_REDO1 = 2'd2,
    ST_REDO2 = 2'd3
  } ctlState_t;

endpackage

// File: rtl/ahl_datapath.sv
module ahl_datapath
  import ahl_pkg::*;
#(
  parameter int OP_W     = 8,
  parameter int ROW_MODE = 0,
  parameter int CNT_W    = $clog2(OP_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpStrobe_t           strobe,
  input  logic [OP_W-1:0]     mdIn,
  input  logic [OP_W-1:0]     mrIn,
  output logic [CNT_W-1:0]    zeroCnt,
  output logic [2*OP_W-1:0]   product
);

  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0] mdHeld;
  logic [OP_W-1:0] mrHeld;
  logic [OP_W-1:0] bypassSrc;
  logic [OP_W-1:0] mulA;
  logic [OP_W-1:0] mulB;
  logic [PROD_W-1:0] mulOut;

  // Operand whose bits steer the bypass multiplexers
  generate
    if (ROW_MODE != 0) begin : g_rowSel
      assign bypassSrc = mrIn;
    end else begin : g_colSel
      assign bypassSrc = mdIn;
    end
  endgenerate

  always_comb begin
    zeroCnt = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (!bypassSrc[i]) zeroCnt = zeroCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdHeld <= '0;
      mrHeld <= '0;
    end else if (strobe.loadOps) begin
      mdHeld <= mdIn;
      mrHeld <= mrIn;
    end
  end

  assign mulA   = strobe.useHeld ? mdHeld : mdIn;
  assign mulB   = strobe.useHeld ? mrHeld : mrIn;
  assign mulOut = PROD_W'(mulA) * PROD_W'(mulB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
    end else if (strobe.capture) begin
      product <= mulOut;
    end
  end

endmodule

// File: rtl/ahl_age_indicator.sv
module ahl_age_indicator #(
  parameter int AGE_LIMIT  = 4,
  parameter int WINDOW_OPS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic errEvent,
  input  logic doneEvent,
  output logic agedMode
);

  localparam int AGE_W = $clog2(AGE_LIMIT + 1);
  localparam int WIN_W = $clog2(WINDOW_OPS);

  logic [AGE_W-1:0] ageCnt;
  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ageCnt   <= '0;
      winCnt   <= '0;
      agedMode <= 1'b0;
    end else if (errEvent) begin
      if (!agedMode) begin
        if (ageCnt == AGE_W'(AGE_LIMIT - 1)) begin
          agedMode <= 1'b1;
          ageCnt   <= '0;
        end else begin
          ageCnt <= ageCnt + AGE_W'(1);
        end
      end
    end else if (doneEvent) begin
      if (winCnt == WIN_W'(WINDOW_OPS - 1)) begin
        winCnt <= '0;
        ageCnt <= '0;
      end else begin
        winCnt <= winCnt + WIN_W'(1);
      end
    end
  end

endmodule

// File: rtl/ahl_control.sv
module ahl_control
  import ahl_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int NORM_ZEROS = 4,
  parameter int AGED_ZEROS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             timingErr,
  input  logic [CNT_W-1:0] zeroCnt,
  input  logic             agedMode,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             resultValid,
  output logic             errEvent,
  output logic             doneEvent
);

  ctlState_t state;
  ctlState_t stateNxt;
  logic      shortOp;

  assign shortOp = agedMode ? (zeroCnt >= CNT_W'(AGED_ZEROS))
                            : (zeroCnt >= CNT_W'(NORM_ZEROS));

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    errEvent = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadOps = 1'b1;
          if (shortOp) begin
            if (timingErr) begin
              errEvent = 1'b1;
              stateNxt = ST_REDO1;
            end else begin
              strobe.capture = 1'b1;
            end
          end else begin
            stateNxt = ST_LONG;
          end
        end
      end
      ST_LONG: begin
        strobe.useHeld = 1'b1;
        if (timingErr) begin
          errEvent = 1'b1;
          stateNxt = ST_REDO1;
        end else begin
          strobe.capture = 1'b1;
          stateNxt       = ST_IDLE;
        end
      end
      ST_REDO1: begin
        stateNxt = ST_REDO2;
      end
      ST_REDO2: begin
        strobe.useHeld = 1'b1;
        strobe.capture = 1'b1;
        stateNxt       = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign doneEvent = strobe.capture;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      resultValid <= 1'b0;
    end else begin
      state       <= stateNxt;
      resultValid <= strobe.capture;
    end
  end

endmodule

// File: rtl/ahl_mult.sv
module ahl_mult
  import ahl_pkg::*;
#(
  parameter int OP_W       = 8,
  parameter int ROW_MODE   = 0,
  parameter int NORM_ZEROS = (OP_W + 1) / 2,
  parameter int AGED_ZEROS = (OP_W + 1) / 2 + 1,
  parameter int AGE_LIMIT  = 4,
  parameter int WINDOW_OPS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   mdIn,
  input  logic [OP_W-1:0]   mrIn,
  input  logic              timingErr,
  output logic              busy,
  output logic              resultValid,
  output logic [2*OP_W-1:0] product,
  output logic              agedMode
);

  localparam int CNT_W = $clog2(OP_W + 1);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] zeroCnt;
  logic             errEvent;
  logic             doneEvent;

  ahl_datapath #(
    .OP_W(OP_W), .ROW_MODE(ROW_MODE), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .mdIn(mdIn), .mrIn(mrIn), .zeroCnt(zeroCnt), .product(product)
  );

  ahl_control #(
    .CNT_W(CNT_W), .NORM_ZEROS(NORM_ZEROS), .AGED_ZEROS(AGED_ZEROS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .timingErr(timingErr),
    .zeroCnt(zeroCnt), .agedMode(agedMode), .strobe(strobe),
    .busy(busy), .resultValid(resultValid),
    .errEvent(errEvent), .doneEvent(doneEvent)
  );

  ahl_age_indicator #(
    .AGE_LIMIT(AGE_LIMIT), .WINDOW_OPS(WINDOW_OPS)
  ) u_age (
    .clk(clk), .rst_n(rst_n), .errEvent(errEvent),
    .doneEvent(doneEvent), .agedMode(agedMode)
  );

endmodule

// File: rtl/ahl_mult_checker.sv
module ahl_mult_checker #(
  parameter int PROD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              resultValid,
  input logic              agedMode,
  input logic              errEvent,
  input logic [PROD_W-1:0] product
);

  // R6: aged mode never drops back without reset
  a_r6_aged_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    agedMode |=> agedMode);

  // R1: product only moves together with a valid pulse
  a_r1_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> resultValid);

  // R4: a flagged capture yields no result next cycle
  a_r4_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    errEvent |=> !resultValid);

  // R4: re-execution spans two busy cycles then delivers
  a_r4_redo_timing: assert property (@(posedge clk) disable iff (!rst_n)
    errEvent |=> busy ##1 busy ##1 resultValid);

  // R8: a delivered result leaves the block idle
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> !busy);

endmodule

bind ahl_mult ahl_mult_checker #(.PROD_W(2 * OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .resultValid(resultValid),
  .agedMode(agedMode), .errEvent(errEvent), .product(product)
);

// File: tb/ahl_mult_test.sv
module ahl_mult_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mdIn = '0;
  logic [7:0]  mrIn = '0;
  logic        timingErr = 1'b0;
  logic        busy;
  logic        resultValid;
  logic [15:0] product;
  logic        agedMode;

  int  total = 0;
  int  fails = 0;
  bit  expAged = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ahl_mult uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mdIn(mdIn), .mrIn(mrIn),
    .timingErr(timingErr), .busy(busy), .resultValid(resultValid),
    .product(product), .agedMode(agedMode)
  );

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int zeros8(input logic [7:0] v);
    int z = 0;
    for (int i = 0; i < 8; i++) if (!v[i]) z++;
    return z;
  endfunction

  // Issue one operation; err keeps timingErr high through the whole op
  task automatic run_op(input logic [7:0] md, input logic [7:0] mr,
                        input bit err, input string tag);
    int   lat;
    int   gotN = 0;
    bit   busyBad = 1'b0;
    bit   shortOp;
    logic [15:0] gotP = '0;
    logic [15:0] expP;
    shortOp = zeros8(md) >= (expAged ? 5 : 4);
    lat  = shortOp ? (err ? 3 : 1) : (err ? 4 : 2);
    expP = 16'(md) * 16'(mr);
    @(negedge clk);
    start = 1'b1; mdIn = md; mrIn = mr; timingErr = err;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (resultValid && gotN == 0) begin
        gotN = n;
        gotP = product;
      end
      if (busy !== (n < lat)) busyBad = 1'b1;
      // extra start while busy must be ignored (R8); idle error ignored (R5)
      start     = (n < lat);
      mdIn      = ~md;
      mrIn      = mr ^ 8'h5A;
      timingErr = (n < lat) ? err : 1'b1;
    end
    start = 1'b0; timingErr = 1'b0;
    check(gotN == lat && gotP == expP && !busyBad,
          $sformatf("%s md=%h mr=%h err=%0d: latency %0d exp %0d, product %h exp %h, busyBad %0d",
                    tag, md, mr, err, gotN, lat, gotP, expP, busyBad));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busy === 1'b0, $sformatf("R9 busy %b exp 0", busy));
    check(resultValid === 1'b0, $sformatf("R9 resultValid %b exp 0", resultValid));
    check(product === 16'h0, $sformatf("R9 product %h exp 0000", product));
    check(agedMode === 1'b0, $sformatf("R9 agedMode %b exp 0", agedMode));
    rst_n = 1'b1;

    // R4 R5: three flagged operations, short and long
    run_op(8'h00, 8'hFF, 1'b1, "R4 R5 short err");
    run_op(8'hFF, 8'hFF, 1'b1, "R4 R5 long err");
    run_op(8'h0F, 8'hC3, 1'b1, "R4 R5 edge err");
    check(agedMode === 1'b0, $sformatf("R6 agedMode %b exp 0 after 3 errors", agedMode));

    // R1 R2 R8: normal-mode sweep, window wraps at completion 256 (R7)
    for (int v = 0; v < 256; v++)
      run_op(8'(v), 8'(v * 29 + 7), 1'b0, "R1 R2 R8 normal");

    run_op(8'h81, 8'h7E, 1'b1, "R4 post-window err");
    run_op(8'h10, 8'h02, 1'b1, "R4 post-window err");
    run_op(8'hF7, 8'h99, 1'b1, "R4 post-window err");
    check(agedMode === 1'b0, $sformatf("R7 agedMode %b exp 0 after window clear", agedMode));

    run_op(8'h3C, 8'hAB, 1'b1, "R4 fourth err");
    check(agedMode === 1'b1, $sformatf("R6 agedMode %b exp 1 at limit", agedMode));
    expAged = 1'b1;

    // R3: aged-mode sweep, four zeros now take two cycles
    for (int v = 0; v < 256; v++)
      run_op(8'(v), 8'(v) ^ 8'hA5, 1'b0, "R3 R1 aged");
    run_op(8'hF0, 8'h11, 1'b1, "R4 aged err");
    check(agedMode === 1'b1, $sformatf("R6 agedMode %b exp 1 sticky", agedMode));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule